// File: doc/BRIEF.md
# SYSREF-Aligned Multiframe Phase Generator

This block produces the local multiframe or extended-multiblock timing reference for one side of a serial converter link. The reference is a free-running phase counter that restarts every period. A single-cycle boundary pulse marks the first cycle of each period. The period is set in core clock cycles. In the 8b/10b line-coding mode it is frames per multiframe times core cycles per frame. In the 64b/66b mode it is multiblocks per extended multiblock times core cycles per multiblock.

The system reference input is asynchronous. It passes through a two-stage synchroniser, and only a rising edge counts as an alignment event. That event is held back by a programmable number of core cycles before it restarts the phase counter. Changing the hold-back moves every boundary by the same number of cycles. Integrators use this to keep lane skew from straddling a boundary, and to keep the data that sits in a two-multiblock receive alignment buffer below its limit before each release. The same block serves transmit and receive. A sticky flag records that an alignment event moved the phase. A clear input resets the flag.

Top module: `mfclk_phase_gen`

## Requirements
- R1: A SYSREF level that stays high for many cycles yields exactly one alignment event. Only a low-to-high transition, seen after two synchroniser flops, counts.
- R2: Let SYSREF be first sampled high at clock edge k, and let the hold-back be D (1 to 255). Then phase_count reads 0 and boundary is 1 in the cycle that follows clock edge k+2+D.
- R3: With a hold-back of 0 there is no added delay: phase_count is 0 and boundary is 1 in the cycle that follows edge k+2.
- R4: The hold-back value is taken at the moment the edge is detected. A new edge that arrives while a countdown is pending restarts the countdown from the new edge, and the earlier pending event never fires.
- R5: Between alignment events, phase_count rises by one each cycle. It returns to 0 after it reaches period-1, and boundary is 1 for exactly the cycles in which phase_count has just returned to 0.
- R6: When mode_64b66b is 0, the period equals frames_per_mf × cycles_per_frame.
- R7: When mode_64b66b is 1, the period equals mb_per_emb × cycles_per_mb.
- R8: A period product of zero is treated as a period of one: phase_count stays 0 and boundary is 1 on every cycle.
- R9: phase_moved becomes 1 when an alignment event lands on a cycle where the counter was not at period-1. It keeps its value when the event coincides with a natural wrap.
- R10: A 1 on status_clear clears phase_moved on the next edge. If an event that moves the phase occurs in the same cycle, setting takes priority.
- R11: While rst_n is low, phase_count is 0, boundary is 0 and phase_moved is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_in | input | 1 | Asynchronous system reference |
| mode_64b66b | input | 1 | 0: 8b/10b multiframe period, 1: 64b/66b extended multiblock period |
| hold_cycles | input | DLY_W (8) | Core cycles of delay after capture |
| frames_per_mf | input | FACT_W (8) | Frames per multiframe |
| cycles_per_frame | input | FACT_W (8) | Core cycles per frame |
| mb_per_emb | input | FACT_W (8) | Multiblocks per extended multiblock |
| cycles_per_mb | input | FACT_W (8) | Core cycles per multiblock |
| status_clear | input | 1 | Clears the phase-moved flag |
| boundary | output | 1 | Single-cycle period start pulse |
| phase_count | output | PHASE_W (16) | Cycle index within the current period |
| phase_moved | output | 1 | Sticky flag: an alignment event shifted the phase |

## Verification
The bench drives SYSREF edges with hold-backs of 0, mid-range values and 255. A capture stage with one synchroniser flop too few or too many would put every realignment one cycle off, and the per-cycle phase comparison would catch that. It re-arms SYSREF during a pending countdown: a delay that ignores the new edge would realign twice. It holds SYSREF high for a long time, where a level-triggered capture would keep forcing the counter to 0. It also times an event to fall exactly on a natural wrap, so a flag that sets on every event shows up. Finally, it forces a zero period product and clears the flag in the same cycle as an event that moves the phase.

// File: rtl/mfclk_pkg.sv
package mfclk_pkg;

  // Period length in core cycles; a zero product becomes one.
  function automatic logic [31:0] period_cycles(
    input logic        use_emb,
    input logic [15:0] frames,
    input logic [15:0] per_frame,
    input logic [15:0] blocks,
    input logic [15:0] per_block
  );
    logic [31:0] prod;
    prod = use_emb ? (32'(blocks) * 32'(per_block))
                   : (32'(frames) * 32'(per_frame));
    return (prod == 32'd0) ? 32'd1 : prod;
  endfunction

endpackage

// File: rtl/sysref_capture.sv
module sysref_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sysref_in,
  output logic edge_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= sysref_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_evt = sync_q[SYNC_STAGES-1] & ~last_q;

  // R1
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> !edge_evt);
endmodule

// File: rtl/sysref_delay.sv
module sysref_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_evt,
  input  logic [DLY_W-1:0] hold_cycles,
  output logic             fire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);
  logic [DLY_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain_q <= '0;
    else if (edge_evt)         remain_q <= hold_cycles;
    else if (remain_q != '0)   remain_q <= remain_q - ONE;
  end

  assign fire = edge_evt ? (hold_cycles == '0) : (remain_q == ONE);

  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && hold_cycles == '0) |-> fire);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (remain_q == $past(hold_cycles)));
  // R4
  no_early_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && hold_cycles > ONE) |=> !fire);
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [PHASE_W-1:0] period,
  input  logic               status_clear,
  output logic [PHASE_W-1:0] phase_count,
  output logic               boundary,
  output logic               phase_moved
);
  localparam logic [PHASE_W-1:0] STEP = PHASE_W'(1);
  logic wrap_now;
  logic shift_evt;

  assign wrap_now  = (phase_count >= period - STEP);
  assign shift_evt = fire & ~wrap_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_count <= '0;
      boundary    <= 1'b0;
    end else if (fire || wrap_now) begin
      phase_count <= '0;
      boundary    <= 1'b1;
    end else begin
      phase_count <= phase_count + STEP;
      boundary    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            phase_moved <= 1'b0;
    else if (shift_evt)    phase_moved <= 1'b1;
    else if (status_clear) phase_moved <= 1'b0;
  end

  // R5
  boundary_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> (phase_count == '0));
  // R2
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (boundary && phase_count == '0));
  // R9
  moved_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_moved) |-> $past(fire));
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clear && !fire) |=> !phase_moved);
endmodule

// File: rtl/mfclk_phase_gen.sv
module mfclk_phase_gen #(
  parameter int DLY_W   = 8,
  parameter int FACT_W  = 8,
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sysref_in,
  input  logic               mode_64b66b,
  input  logic [DLY_W-1:0]   hold_cycles,
  input  logic [FACT_W-1:0]  frames_per_mf,
  input  logic [FACT_W-1:0]  cycles_per_frame,
  input  logic [FACT_W-1:0]  mb_per_emb,
  input  logic [FACT_W-1:0]  cycles_per_mb,
  input  logic               status_clear,
  output logic               boundary,
  output logic [PHASE_W-1:0] phase_count,
  output logic               phase_moved
);
  import mfclk_pkg::*;

  logic               edge_evt;
  logic               fire;
  logic [PHASE_W-1:0] period;
  logic [31:0]        period_full;

  assign period_full = period_cycles(mode_64b66b,
                                     16'(frames_per_mf), 16'(cycles_per_frame),
                                     16'(mb_per_emb),    16'(cycles_per_mb));
  assign period = PHASE_W'(period_full);

  sysref_capture #(.SYNC_STAGES(2)) u_capture (
    .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .edge_evt(edge_evt)
  );

  sysref_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt),
    .hold_cycles(hold_cycles), .fire(fire)
  );

  phase_counter #(.PHASE_W(PHASE_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .fire(fire), .period(period),
    .status_clear(status_clear), .phase_count(phase_count),
    .boundary(boundary), .phase_moved(phase_moved)
  );

  // R8
  period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period != '0);
endmodule

// File: tb/mfclk_phase_gen_bench.sv
module mfclk_phase_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sysref_in = 1'b0;
  logic        mode_64b66b = 1'b0;
  logic [7:0]  hold_cycles = 8'd0;
  logic [7:0]  frames_per_mf = 8'd4;
  logic [7:0]  cycles_per_frame = 8'd2;
  logic [7:0]  mb_per_emb = 8'd3;
  logic [7:0]  cycles_per_mb = 8'd4;
  logic        status_clear = 1'b0;
  logic        boundary;
  logic [15:0] phase_count;
  logic        phase_moved;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R11";
  bit done = 0;

  // scoreboard: cycle numbers at which the phase must restart
  int exp_q[$];
  int m_phase = 0;
  bit m_bnd = 0;
  bit m_moved = 0;

  always #2.5 clk = ~clk;

  mfclk_phase_gen u_mfclk_phase_gen (
    .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .mode_64b66b(mode_64b66b),
    .hold_cycles(hold_cycles), .frames_per_mf(frames_per_mf),
    .cycles_per_frame(cycles_per_frame), .mb_per_emb(mb_per_emb),
    .cycles_per_mb(cycles_per_mb), .status_clear(status_clear),
    .boundary(boundary), .phase_count(phase_count), .phase_moved(phase_moved)
  );

  function automatic int ref_len();
    int p;
    p = mode_64b66b ? int'(mb_per_emb) * int'(cycles_per_mb)
                    : int'(frames_per_mf) * int'(cycles_per_frame);
    return (p == 0) ? 1 : p;
  endfunction

  // reference model advanced at each edge from requirement text
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_bnd = 0; m_moved = 0; cyc = 0;
    end else begin
      cyc = cyc + 1;
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        void'(exp_q.pop_front());
        if (m_phase != ref_len() - 1) m_moved = 1;
        else if (status_clear) m_moved = 0;
        m_phase = 0; m_bnd = 1;
      end else begin
        if (status_clear) m_moved = 0;
        if (m_phase >= ref_len() - 1) begin m_phase = 0; m_bnd = 1; end
        else begin m_phase = m_phase + 1; m_bnd = 0; end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: compares outputs against the scoreboard model away from the edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check("R11", int'(phase_count), 0, "reset phase");
        check("R11", int'(boundary), 0, "reset boundary");
        check("R11", int'(phase_moved), 0, "reset flag");
      end else begin
        check(cur_req, int'(phase_count), m_phase, "phase");
        check(cur_req, int'(boundary), int'(m_bnd), "boundary");
        check(cur_req, int'(phase_moved), int'(m_moved), "phase_moved");
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: raises SYSREF for hi cycles and books the expected restart
  task automatic send_sysref(input int hi, input int lo);
    @(negedge clk);
    while (exp_q.size() > 0 && exp_q[exp_q.size()-1] >= cyc + 3)
      void'(exp_q.pop_back()); // R4 pending event is superseded
    exp_q.push_back(cyc + 3 + int'(hold_cycles));
    sysref_in = 1'b1;
    idle(hi);
    sysref_in = 1'b0;
    idle(lo);
  endtask

  initial begin
    #(5 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    cur_req = "R6"; idle(30);                 // R5 R6 free-running 8-cycle period
    cur_req = "R3"; hold_cycles = 0; send_sysref(2, 20);
    cur_req = "R1"; hold_cycles = 3; send_sysref(40, 20);
    cur_req = "R2"; hold_cycles = 5; send_sysref(2, 25);
    hold_cycles = 13; send_sysref(3, 30);
    // R10 clear the flag, then land an event exactly on a wrap (R9)
    cur_req = "R10"; status_clear = 1'b1; idle(2); status_clear = 1'b0;
    cur_req = "R9"; hold_cycles = 6;
    while (((m_phase + 4 + 6) % ref_len()) != 0) idle(1);
    send_sysref(2, 25);
    // R10 set wins over a same-cycle clear
    cur_req = "R10"; hold_cycles = 2;
    while (((m_phase + 4 + 2) % ref_len()) != 3) idle(1);
    send_sysref(1, 0);
    status_clear = 1'b1; idle(6); status_clear = 1'b0; idle(10);
    // R4 restart with a fresh hold-back
    cur_req = "R4"; hold_cycles = 20; send_sysref(2, 4);
    hold_cycles = 7; send_sysref(2, 30);
    // R7 extended multiblock period, longest hold-back
    cur_req = "R7"; mode_64b66b = 1'b1; idle(30);
    hold_cycles = 8'd255; send_sysref(2, 280);
    status_clear = 1'b1; idle(1); status_clear = 1'b0;
    cur_req = "R7"; mb_per_emb = 8'd5; cycles_per_mb = 8'd3; idle(40);
    // R8 zero product
    cur_req = "R8"; mb_per_emb = 8'd0; idle(10);
    hold_cycles = 4; send_sysref(2, 12);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule